// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Fixed Off-Time Chopping

This block drives the four gate enables of one full H-bridge: a high-side and a low-side switch on each of two output legs. Two direction inputs select coast, forward, reverse or brake. A current-trip flag from an external sense comparator cuts a drive phase short. When that happens the bridge is held in a timed low-side brake, and driving then resumes. Every change between the two switches of a leg waits out a dead gap.

All timing is counted in cycles of a fixed system clock. The blanking window, the off time, the dead gap and the wake delay are each a parameter. The direction inputs and the trip flag pass through a two-flop synchroniser before use.

A sleep request forces all switches off and clears every register. After the request is released, or after reset, the gates stay off for the wake delay before the inputs take effect.

Top module: `hbridge_chopper`

## Requirements
- R1: With `{in_a_i,in_b_i}` = 00 (coast) all four gate enables settle to 0.
- R2: `{in_a_i,in_b_i}` = 10 (forward) settles to leg-1 high and leg-2 low on. 01 (reverse) settles to leg-1 low and leg-2 high on.
- R3: `{in_a_i,in_b_i}` = 11 (brake) settles to both low sides on and both high sides off.
- R4: The two switches of a leg are never on together. A switch turns on only after the other switch of its leg has been off for at least DEAD_CYC+1 cycles. A leg whose command changes between high and low shows both switches off from the 3rd through the (3+DEAD_CYC)th edge after the input change, and the new switch on at the (4+DEAD_CYC)th edge.
- R5: A drive command (forward or reverse) opens a blanking window of BLANK_CYC cycles. The trip flag is ignored inside that window, and it is ignored at all times in coast and brake.
- R6: An unblanked trip during drive turns the high side off on the next edge and turns both low sides on after the dead gap. The bridge stays in this brake for OFF_CYC cycles and then returns to the commanded drive.
- R7: A change between drive and brake commands made during the off time is held back until the off time ends.
- R8: A coast command made during the off time ends it at once: the gates go off at the normal input latency.
- R9: One edge after `sleep_i` is seen high all gates are 0, and the inputs have no effect while it stays high.
- R10: After reset or after `sleep_i` falls, the gates stay 0 for WAKE_CYC edges. The commanded state may first appear at edge WAKE_CYC+1.
- R11: An input change reaches the gates no earlier than the 3rd rising edge after it (two synchroniser flops plus the gate register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_a_i | input | 1 | Direction/PWM input A (asynchronous) |
| in_b_i | input | 1 | Direction/PWM input B (asynchronous) |
| trip_i | input | 1 | Current-trip comparator flag (asynchronous) |
| sleep_i | input | 1 | Sleep request, active high |
| leg1_hi_o | output | 1 | Leg 1 high-side gate enable |
| leg1_lo_o | output | 1 | Leg 1 low-side gate enable |
| leg2_hi_o | output | 1 | Leg 2 high-side gate enable |
| leg2_lo_o | output | 1 | Leg 2 low-side gate enable |

## Verification
An input edge driven between clock edges shows at the gates after the third rising edge when a switch turns on from idle. A switch that follows the other switch of its leg appears only at edge 4+DEAD_CYC. The bench therefore samples one step before and one step after each due edge.

A trip raised with the drive command is accepted at edge 4+BLANK_CYC. The high side drops one edge later and the low side rises DEAD_CYC+1 edges after that. The brake releases OFF_CYC edges after the trip is accepted. Each chop check is placed on these counts, and so are the wake checks at edges WAKE_CYC and WAKE_CYC+1.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    MODE_COAST = 2'b00,
    MODE_REV   = 2'b01,
    MODE_FWD   = 2'b10,
    MODE_BRAKE = 2'b11
  } hb_mode_e;

  typedef enum logic [1:0] {
    LEG_OFF = 2'b00,
    LEG_HI  = 2'b01,
    LEG_LO  = 2'b10
  } leg_cmd_e;

  function automatic leg_cmd_e leg_cmd(hb_mode_e m, logic second);
    case (m)
      MODE_FWD:   return second ? LEG_LO : LEG_HI;
      MODE_REV:   return second ? LEG_HI : LEG_LO;
      MODE_BRAKE: return LEG_LO;
      default:    return LEG_OFF;
    endcase
  endfunction
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (clr_i) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/hb_leg.sv
module hb_leg #(
  parameter int DEAD_CYC = 45
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  hb_pkg::leg_cmd_e cmd_i,
  output logic             hi_o,
  output logic             lo_o
);
  import hb_pkg::*;
  localparam int DW = $clog2(DEAD_CYC + 1);

  logic          hi_q, lo_q;
  logic [DW-1:0] dcnt_q;
  logic          want_hi, want_lo;

  assign want_hi = (cmd_i == LEG_HI);
  assign want_lo = (cmd_i == LEG_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      dcnt_q <= '0;
    end else if (clr_i) begin
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      dcnt_q <= '0;
    end else if ((hi_q && !want_hi) || (lo_q && !want_lo)) begin
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      dcnt_q <= '0;
    end else if (!hi_q && !lo_q) begin
      // both off: count the gap, then close the requested switch
      if (dcnt_q == DW'(DEAD_CYC)) begin
        hi_q <= want_hi;
        lo_q <= want_lo;
      end else begin
        dcnt_q <= dcnt_q + 1'b1;
      end
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  a_r4_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_q && lo_q));
  a_r4_gap_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_q) |-> (!$past(lo_q) && !$past(lo_q, 2)));
  a_r4_gap_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lo_q) |-> (!$past(hi_q) && !$past(hi_q, 2)));
endmodule

// File: rtl/hb_chop_ctrl.sv
module hb_chop_ctrl #(
  parameter int BLANK_CYC = 375,
  parameter int OFF_CYC   = 2000,
  parameter int WAKE_CYC  = 15500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  hb_pkg::hb_mode_e mode_i,
  input  logic             trip_i,
  output hb_pkg::hb_mode_e target_o,
  output logic             wake_o,
  output logic             off_o
);
  import hb_pkg::*;
  localparam int CNT_MAX = (OFF_CYC > WAKE_CYC) ? OFF_CYC : WAKE_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int BW      = $clog2(BLANK_CYC + 1);

  typedef enum logic [1:0] {ST_WAKE, ST_RUN, ST_OFF} st_e;

  st_e           st_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] blank_q;
  hb_mode_e      mode_q;
  logic          drive, trip_take;

  assign drive     = (mode_i == MODE_FWD) || (mode_i == MODE_REV);
  assign trip_take = (st_q == ST_RUN) && drive && trip_i && (blank_q == BW'(BLANK_CYC));

  always_comb begin
    case (st_q)
      ST_WAKE: target_o = MODE_COAST;
      ST_OFF:  target_o = (mode_i == MODE_COAST) ? MODE_COAST : MODE_BRAKE;
      default: target_o = mode_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_WAKE;
      cnt_q   <= '0;
      blank_q <= '0;
      mode_q  <= MODE_COAST;
    end else if (sleep_i) begin
      st_q    <= ST_WAKE;
      cnt_q   <= '0;
      blank_q <= '0;
      mode_q  <= MODE_COAST;
    end else begin
      mode_q <= mode_i;
      case (st_q)
        ST_WAKE: begin
          if (cnt_q == CW'(WAKE_CYC - 1)) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RUN: begin
          if (trip_take) begin
            st_q  <= ST_OFF;
            cnt_q <= '0;
          end
        end
        default: begin
          if (mode_i == MODE_COAST || cnt_q == CW'(OFF_CYC - 1)) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
      // blanking restarts on each new drive phase
      if (st_q != ST_RUN || !drive || mode_i != mode_q) blank_q <= '0;
      else if (blank_q != BW'(BLANK_CYC)) blank_q <= blank_q + 1'b1;
    end
  end

  assign wake_o = (st_q == ST_WAKE);
  assign off_o  = (st_q == ST_OFF);

  a_r6_off_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OFF) |-> (cnt_q < CW'(OFF_CYC)));
  a_r5_blank_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OFF && $past(st_q) == ST_RUN) |-> ($past(blank_q) == BW'(BLANK_CYC)));
endmodule

// File: rtl/hbridge_chopper.sv
module hbridge_chopper #(
  parameter int DEAD_CYC  = 45,
  parameter int BLANK_CYC = 375,
  parameter int OFF_CYC   = 2000,
  parameter int WAKE_CYC  = 15500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_a_i,
  input  logic in_b_i,
  input  logic trip_i,
  input  logic sleep_i,
  output logic leg1_hi_o,
  output logic leg1_lo_o,
  output logic leg2_hi_o,
  output logic leg2_lo_o
);
  import hb_pkg::*;
  localparam int NLEG = 2;

  logic [2:0]      sync_q;
  hb_mode_e        mode_s, target;
  logic            wake_s, off_s;
  logic [NLEG-1:0] hi_w, lo_w;

  hb_sync #(.WIDTH(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sleep_i),
    .d_i    ({in_a_i, in_b_i, trip_i}),
    .q_o    (sync_q)
  );

  assign mode_s = hb_mode_e'(sync_q[2:1]);

  hb_chop_ctrl #(
    .BLANK_CYC (BLANK_CYC),
    .OFF_CYC   (OFF_CYC),
    .WAKE_CYC  (WAKE_CYC)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sleep_i  (sleep_i),
    .mode_i   (mode_s),
    .trip_i   (sync_q[0]),
    .target_o (target),
    .wake_o   (wake_s),
    .off_o    (off_s)
  );

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    leg_cmd_e cmd_w;
    assign cmd_w = leg_cmd(target, (g == 1));
    hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (sleep_i),
      .cmd_i  (cmd_w),
      .hi_o   (hi_w[g]),
      .lo_o   (lo_w[g])
    );
  end

  assign leg1_hi_o = hi_w[0];
  assign leg1_lo_o = lo_w[0];
  assign leg2_hi_o = hi_w[1];
  assign leg2_lo_o = lo_w[1];

  a_r9_sleep_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (hi_w == '0 && lo_w == '0));
  a_r10_wake_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_s |-> (hi_w == '0 && lo_w == '0));
  a_r6_off_no_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_s && $past(off_s)) |-> (hi_w == '0));
endmodule

// File: tb/hbridge_chopper_test.sv
module hbridge_chopper_test;
  localparam int CLK_PERIOD = 10;
  localparam int D = 2;
  localparam int B = 4;
  localparam int O = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_a = 1'b0, in_b = 1'b0, trip = 1'b0, sleep = 1'b0;
  logic l1h, l1l, l2h, l2l;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hbridge_chopper #(.DEAD_CYC(D), .BLANK_CYC(B), .OFF_CYC(O), .WAKE_CYC(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_a_i(in_a), .in_b_i(in_b),
    .trip_i(trip), .sleep_i(sleep),
    .leg1_hi_o(l1h), .leg1_lo_o(l1l), .leg2_hi_o(l2h), .leg2_lo_o(l2l)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {l1h, l1l, l2h, l2l};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // {hi,lo} of one leg for mode {a,b}
  function automatic logic [1:0] leg_pat(input logic [1:0] m, input bit second);
    case (m)
      2'b10:   return second ? 2'b01 : 2'b10;
      2'b01:   return second ? 2'b10 : 2'b01;
      2'b11:   return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [3:0] pat(input logic [1:0] m);
    return {leg_pat(m, 0), leg_pat(m, 1)};
  endfunction

  // leg state at the 3rd edge: on-from-idle happens, side swaps are gapped
  function automatic logic [1:0] leg_mid(input logic [1:0] f, input logic [1:0] t, input bit second);
    logic [1:0] o, n;
    o = leg_pat(f, second);
    n = leg_pat(t, second);
    if (o == n) return o;
    if (o == 2'b00) return n;
    return 2'b00;
  endfunction

  function automatic string sweep_tag(input logic [1:0] t);
    if (t == 2'b00) return "R1";
    if (t == 2'b11) return "R3";
    return "R2";
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset state", 4'b0000);
    {in_a, in_b} = 2'b10;
    rst_ni = 1'b1;
    step(W);
    chk("R10 quiet through wake", 4'b0000);
    step(1);
    chk("R10 drive after wake", pat(2'b10));

    // exhaustive mode-to-mode transitions
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        {in_a, in_b} = 2'(f);
        step(12);
        {in_a, in_b} = 2'(t);
        step(2);
        chk("R11 latency hold", pat(2'(f)));
        step(1);
        chk("R4 dead gap", {leg_mid(2'(f), 2'(t), 0), leg_mid(2'(f), 2'(t), 1)});
        step(D + 1);
        chk(sweep_tag(2'(t)), pat(2'(t)));
      end
    end

    // trip ignored outside drive
    {in_a, in_b} = 2'b00;
    trip = 1'b1;
    step(8);
    chk("R5 trip ignored in coast", 4'b0000);
    {in_a, in_b} = 2'b11;
    step(8);
    chk("R5 trip ignored in brake", 4'b0101);
    trip = 1'b0;
    {in_a, in_b} = 2'b00;
    step(12);

    // chop: trip with drive start, accepted at edge 4+B
    {in_a, in_b} = 2'b10;
    trip = 1'b1;
    step(3);
    chk("R2 forward on", 4'b1001);
    step(B + 1);
    chk("R5 blanked through window", 4'b1001);
    step(1);
    chk("R6 high side off", 4'b0001);
    trip = 1'b0;
    step(D + 1);
    chk("R6 slow decay brake", 4'b0101);
    step(5);
    chk("R6 brake held", 4'b0101);
    step(1);
    chk("R6 brake held at end", 4'b0101);
    step(1);
    chk("R6 low side released", 4'b0001);
    step(D + 1);
    chk("R6 drive resumed", 4'b1001);

    // reversal requested during off time is deferred
    trip = 1'b1;
    step(4);
    chk("R6 second chop", 4'b0001);
    trip = 1'b0;
    {in_a, in_b} = 2'b01;
    step(3);
    chk("R7 brake kept during off", 4'b0101);
    step(6);
    chk("R7 brake until off ends", 4'b0101);
    step(1);
    chk("R7 leg2 low released", 4'b0100);
    step(D + 1);
    chk("R7 reverse after off", 4'b0110);

    // coast during off time takes effect at once
    trip = 1'b1;
    step(4);
    chk("R6 reverse chop", 4'b0100);
    trip = 1'b0;
    step(3);
    chk("R6 reverse brake", 4'b0101);
    {in_a, in_b} = 2'b00;
    step(2);
    chk("R11 coast latency", 4'b0101);
    step(1);
    chk("R8 coast ends off time", 4'b0000);

    // sleep and wake
    step(8);
    {in_a, in_b} = 2'b10;
    step(3);
    chk("R2 forward before sleep", 4'b1001);
    sleep = 1'b1;
    step(1);
    chk("R9 sleep clears gates", 4'b0000);
    {in_a, in_b} = 2'b01;
    step(5);
    chk("R9 inputs ignored asleep", 4'b0000);
    sleep = 1'b0;
    step(W);
    chk("R10 quiet after sleep", 4'b0000);
    step(1);
    chk("R10 reverse after wake", 4'b0110);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule